// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

This block is the synchronous control and data path of a pipelined burst SRAM, with a small behavioural array behind it. All synchronous inputs are registered on the rising clock edge. These inputs are the address, the three chip enables, the two address strobes, the burst-advance input, the per-byte write enables, the byte-write enable, the global write and the write data with its parity lanes. The decode happens in the following cycle, where it starts a read, a self-timed write, a burst continuation or a deselect.

Reads are pipelined. The array is read with a synchronous read port, and that registered word drives the output bus. The bus is split into input, output and output-enable ports so that the tristate buffer sits in the pad ring. The output enable is asynchronous and only gates the bus drivers. When the device is deselected, the last read word stays on the bus for one further cycle before the drivers release, which is a double-cycle deselect. Each byte lane carries a ninth parity bit that is stored and returned with the byte.

Top module: `sbf_burst_sram`

## Requirements
- R1: After a synchronous reset the output enable `bus_oe` is low. Until an address strobe selects the device, cycles with no strobe start no operation and leave `bus_oe` low.
- R2: The device counts as selected only when `en0_n`=0, `en1`=1 and `en1_n`=0 at the same edge. An honoured strobe while the device is not selected is a deselect.
- R3: With `cstb_n`=0 and the device selected, the address is loaded. The cycle is a write when a write is requested and a read otherwise. Write data from `bus_d_i` and `bus_p_i` is taken at the same edge as the strobe. `cstb_n` is honoured whatever the level of `pstb_n` when `en0_n`=1.
- R4: `pstb_n` has no effect while `en0_n`=1. The cycle then behaves exactly as if `pstb_n` were high.
- R5: An honoured `pstb_n`=0 always starts a read at the new address. Write controls given at the next edge, with no strobe and `burst_go_n`=1, write the data of that edge to the same address.
- R6: A read whose address is registered at edge k puts its word on `bus_d_o` and `bus_p_o` after edge k+1. `bus_oe` is high from then on, provided `out_en_n` is low.
- R7: With `all_wr_n`=0, all byte lanes are written regardless of `lane_wr_n` and `bytewr_en_n`. Otherwise byte j (bits 8j+7..8j, parity bit j) is written only when `bytewr_en_n`=0 and `lane_wr_n[j]`=0. A cycle with no lane selected is a read.
- R8: Parity bit j on `bus_p_i` is stored with byte j, and it is returned on `bus_p_o[j]` together with that byte.
- R9: `bus_oe` is low whenever `out_en_n` is high, and this follows `out_en_n` without waiting for a clock. A write cycle turns the drivers off after its edge, and a later read turns them back on.
- R10: Suppose the bus is driven and a deselect is registered at edge k. The last word then stays driven and unchanged after edge k+1, and `bus_oe` falls after edge k+2.
- R11: A cycle with no honoured strobe while the device is active keeps the upper address bits. The low two address bits stay the same when `burst_go_n`=1 (suspend) and step by one modulo 4 when `burst_go_n`=0 (linear wrap). The write controls of that cycle choose read or write.
- R12: When `pstb_n`=0 and `en0_n`=0, the processor strobe wins over a simultaneous `cstb_n`=0. The cycle is a read even if write controls are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address |
| en0_n | input | 1 | Primary chip enable, active low; gates the processor strobe |
| en1 | input | 1 | Expansion enable, active high |
| en1_n | input | 1 | Expansion enable, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| burst_go_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | NB | Per-byte write enables, active low |
| bytewr_en_n | input | 1 | Qualifier for the per-byte enables, active low |
| all_wr_n | input | 1 | Global write of all bytes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| bus_d_i | input | NB*8 | Data bus, receive side |
| bus_p_i | input | NB | Parity lanes, receive side |
| bus_d_o | output | NB*8 | Data bus, drive side |
| bus_p_o | output | NB | Parity lanes, drive side |
| bus_oe | output | 1 | Drive enable for the data and parity pads |

## Verification
The bench targets strobe arbitration. A design that lets the processor strobe through with `en0_n` high reloads the address and drives an unexpected word. A design that favours the controller strobe performs a write where a read is expected. The bench also walks the deselect tail. A single-cycle deselect drops `bus_oe` one cycle early, and a stuck one keeps driving after the second edge. Burst wrap is checked at the low-bit boundary, where a carry into the upper bits reads the wrong word. The bench also covers the global-write override and the processor-strobe write one edge late, where a wrong mask or address shows up as stale bytes or parity on readback.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // Operation chosen for a registered cycle; executed at the following edge.
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_DSEL = 2'd3
  } cmd_e;
endpackage

// File: rtl/sbf_capture.sv
// Input register stage: every synchronous pin is sampled on the rising edge.
module sbf_capture #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr_i,
  input  logic            en0_n,
  input  logic            en1,
  input  logic            en1_n,
  input  logic            pstb_n,
  input  logic            cstb_n,
  input  logic            burst_go_n,
  input  logic [NB-1:0]   lane_wr_n,
  input  logic            bytewr_en_n,
  input  logic            all_wr_n,
  input  logic [NB*8-1:0] d_i,
  input  logic [NB-1:0]   p_i,
  output logic [AW-1:0]   addr_q,
  output logic            en0_n_q,
  output logic            en1_q,
  output logic            en1_n_q,
  output logic            pstb_n_q,
  output logic            cstb_n_q,
  output logic            go_n_q,
  output logic [NB-1:0]   lane_wr_n_q,
  output logic            bytewr_en_n_q,
  output logic            all_wr_n_q,
  output logic [NB*8-1:0] d_q,
  output logic [NB-1:0]   p_q
);
  // Control flops reset to their inactive levels.
  always_ff @(posedge clk) begin
    if (rst) begin
      en0_n_q       <= 1'b1;
      en1_q         <= 1'b0;
      en1_n_q       <= 1'b1;
      pstb_n_q      <= 1'b1;
      cstb_n_q      <= 1'b1;
      go_n_q        <= 1'b1;
      lane_wr_n_q   <= '1;
      bytewr_en_n_q <= 1'b1;
      all_wr_n_q    <= 1'b1;
    end else begin
      en0_n_q       <= en0_n;
      en1_q         <= en1;
      en1_n_q       <= en1_n;
      pstb_n_q      <= pstb_n;
      cstb_n_q      <= cstb_n;
      go_n_q        <= burst_go_n;
      lane_wr_n_q   <= lane_wr_n;
      bytewr_en_n_q <= bytewr_en_n;
      all_wr_n_q    <= all_wr_n;
    end
  end

  // Address and data flops need no reset.
  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    d_q    <= d_i;
    p_q    <= p_i;
  end
endmodule

// File: rtl/sbf_seq.sv
// Cycle decoder and address/activity state.
module sbf_seq
  import sbf_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_q,
  input  logic          en0_n_q,
  input  logic          en1_q,
  input  logic          en1_n_q,
  input  logic          pstb_n_q,
  input  logic          cstb_n_q,
  input  logic          go_n_q,
  input  logic [NB-1:0] lane_wr_n_q,
  input  logic          bytewr_en_n_q,
  input  logic          all_wr_n_q,
  output cmd_e          cmd,
  output logic [AW-1:0] cmd_addr,
  output logic [NB-1:0] wmask
);
  localparam int LOW_W = 2;

  logic          act_q;
  logic [AW-1:0] addr_r;
  logic          sel;
  logic [NB-1:0] req_mask;
  logic          wr_req;
  logic          nxt_act;
  logic [AW-1:0] burst_addr;

  assign sel      = ~en0_n_q & en1_q & ~en1_n_q;
  assign req_mask = ~all_wr_n_q ? {NB{1'b1}} : (~bytewr_en_n_q ? ~lane_wr_n_q : '0);
  assign wr_req   = |req_mask;
  assign burst_addr = {addr_r[AW-1:LOW_W], addr_r[LOW_W-1:0] + 2'd1};

  always_comb begin
    cmd      = CMD_NONE;
    cmd_addr = addr_r;
    nxt_act  = act_q;
    if (~pstb_n_q & ~en0_n_q) begin
      // processor strobe: highest priority, always a read
      if (sel) begin
        cmd      = CMD_RD;
        cmd_addr = addr_q;
        nxt_act  = 1'b1;
      end else begin
        cmd     = act_q ? CMD_DSEL : CMD_NONE;
        nxt_act = 1'b0;
      end
    end else if (~cstb_n_q) begin
      if (sel) begin
        cmd      = wr_req ? CMD_WR : CMD_RD;
        cmd_addr = addr_q;
        nxt_act  = 1'b1;
      end else begin
        cmd     = act_q ? CMD_DSEL : CMD_NONE;
        nxt_act = 1'b0;
      end
    end else if (act_q) begin
      if (~go_n_q) cmd_addr = burst_addr;
      cmd = wr_req ? CMD_WR : CMD_RD;
    end
  end

  assign wmask = (cmd == CMD_WR) ? req_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      addr_r <= '0;
    end else begin
      act_q  <= nxt_act;
      addr_r <= cmd_addr;
    end
  end
endmodule

// File: rtl/sbf_lane.sv
// One byte lane (data plus parity) of the array, synchronous read port.
module sbf_lane #(
  parameter int AW = 6,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wd,
  output logic [LW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd_q <= mem[addr];
  end
endmodule

// File: rtl/sbf_burst_sram.sv
module sbf_burst_sram
  import sbf_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr_i,
  input  logic            en0_n,
  input  logic            en1,
  input  logic            en1_n,
  input  logic            pstb_n,
  input  logic            cstb_n,
  input  logic            burst_go_n,
  input  logic [NB-1:0]   lane_wr_n,
  input  logic            bytewr_en_n,
  input  logic            all_wr_n,
  input  logic            out_en_n,
  input  logic [NB*8-1:0] bus_d_i,
  input  logic [NB-1:0]   bus_p_i,
  output logic [NB*8-1:0] bus_d_o,
  output logic [NB-1:0]   bus_p_o,
  output logic            bus_oe
);
  localparam int BW = 8;
  localparam int LW = BW + 1;
  localparam int DW = NB * BW;

  logic [AW-1:0] c_addr;
  logic          c_en0_n, c_en1, c_en1_n, c_pstb_n, c_cstb_n, c_go_n;
  logic [NB-1:0] c_lane_wr_n;
  logic          c_bytewr_en_n, c_all_wr_n;
  logic [DW-1:0] c_d;
  logic [NB-1:0] c_p;

  cmd_e          cmd;
  logic [AW-1:0] cmd_addr;
  logic [NB-1:0] wmask;
  logic          drv_q;

  sbf_capture #(.AW(AW), .NB(NB)) u_cap (
    .clk(clk), .rst(rst), .addr_i(addr_i), .en0_n(en0_n), .en1(en1), .en1_n(en1_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .burst_go_n(burst_go_n), .lane_wr_n(lane_wr_n),
    .bytewr_en_n(bytewr_en_n), .all_wr_n(all_wr_n), .d_i(bus_d_i), .p_i(bus_p_i),
    .addr_q(c_addr), .en0_n_q(c_en0_n), .en1_q(c_en1), .en1_n_q(c_en1_n),
    .pstb_n_q(c_pstb_n), .cstb_n_q(c_cstb_n), .go_n_q(c_go_n), .lane_wr_n_q(c_lane_wr_n),
    .bytewr_en_n_q(c_bytewr_en_n), .all_wr_n_q(c_all_wr_n), .d_q(c_d), .p_q(c_p)
  );

  sbf_seq #(.AW(AW), .NB(NB)) u_seq (
    .clk(clk), .rst(rst), .addr_q(c_addr), .en0_n_q(c_en0_n), .en1_q(c_en1),
    .en1_n_q(c_en1_n), .pstb_n_q(c_pstb_n), .cstb_n_q(c_cstb_n), .go_n_q(c_go_n),
    .lane_wr_n_q(c_lane_wr_n), .bytewr_en_n_q(c_bytewr_en_n), .all_wr_n_q(c_all_wr_n),
    .cmd(cmd), .cmd_addr(cmd_addr), .wmask(wmask)
  );

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [LW-1:0] rd;
    sbf_lane #(.AW(AW), .LW(LW)) u_lane (
      .clk(clk), .we(wmask[j]), .re(cmd == CMD_RD), .addr(cmd_addr),
      .wd({c_p[j], c_d[j*BW +: BW]}), .rd_q(rd)
    );
    assign bus_d_o[j*BW +: BW] = rd[BW-1:0];
    assign bus_p_o[j]          = rd[BW];
  end

  // Drive state: set by reads, cleared by writes and idle cycles,
  // held for one extra cycle on the first deselect.
  always_ff @(posedge clk) begin
    if (rst) drv_q <= 1'b0;
    else begin
      unique case (cmd)
        CMD_RD:   drv_q <= 1'b1;
        CMD_WR:   drv_q <= 1'b0;
        CMD_DSEL: drv_q <= drv_q;
        default:  drv_q <= 1'b0;
      endcase
    end
  end

  assign bus_oe = drv_q & ~out_en_n;
endmodule

// File: rtl/sbf_burst_sram_chk.sv
module sbf_burst_sram_chk
  import sbf_pkg::*;
#(
  parameter int NB = 4
) (
  input logic            clk,
  input logic            rst,
  input cmd_e            cmd,
  input logic            drv_q,
  input logic [NB-1:0]   mask,
  input logic            gw_n_q,
  input logic [NB*8-1:0] rd_d,
  input logic [NB-1:0]   rd_p
);
  // R9
  wr_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR) |=> !drv_q);

  // R6
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD) |=> drv_q);

  // R10
  dcd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_DSEL && drv_q) |=> (drv_q && $stable(rd_d) && $stable(rd_p)));

  // R10
  dcd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE) |=> !drv_q);

  // R7
  gw_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR && !gw_n_q) |-> (&mask));

  // R3
  wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR) |-> (mask != '0));

  // R5
  rd_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_WR) |-> (mask == '0));
endmodule

bind sbf_burst_sram sbf_burst_sram_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .drv_q(drv_q), .mask(wmask),
  .gw_n_q(c_all_wr_n), .rd_d(bus_d_o), .rd_p(bus_p_o)
);

// File: tb/tb_sbf_burst_sram.sv
module tb_sbf_burst_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic en0_n = 1'b0, en1 = 1'b1, en1_n = 1'b0;
  logic pstb_n = 1'b1, cstb_n = 1'b1, burst_go_n = 1'b1;
  logic [NB-1:0] lane_wr_n = '1;
  logic bytewr_en_n = 1'b1, all_wr_n = 1'b1, out_en_n = 1'b0;
  logic [DW-1:0] bus_d_i = '0;
  logic [NB-1:0] bus_p_i = '0;
  logic [DW-1:0] bus_d_o;
  logic [NB-1:0] bus_p_o;
  logic bus_oe;

  always #5 clk = ~clk;

  sbf_burst_sram #(.AW(AW), .NB(NB)) dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .en0_n(en0_n), .en1(en1), .en1_n(en1_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .burst_go_n(burst_go_n), .lane_wr_n(lane_wr_n),
    .bytewr_en_n(bytewr_en_n), .all_wr_n(all_wr_n), .out_en_n(out_en_n),
    .bus_d_i(bus_d_i), .bus_p_i(bus_p_i), .bus_d_o(bus_d_o), .bus_p_o(bus_p_o),
    .bus_oe(bus_oe)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] m_d [DEPTH];
  logic [NB-1:0] m_p [DEPTH];
  bit m_act = 0, m_drv = 0;
  int m_addr = 0;
  logic [DW-1:0] m_od = '0;
  logic [NB-1:0] m_op = '0;

  logic [AW-1:0] p_addr;
  bit p_en0_n, p_en1, p_en1_n, p_ps, p_cs, p_go, p_bwe, p_gw;
  logic [NB-1:0] p_lw;
  logic [DW-1:0] p_d;
  logic [NB-1:0] p_p;

  task automatic m_idle_pend();
    p_en0_n = 1; p_en1 = 0; p_en1_n = 1; p_ps = 1; p_cs = 1; p_go = 1;
    p_bwe = 1; p_gw = 1; p_lw = '1;
  endtask

  task automatic m_commit();
    bit sel;
    logic [NB-1:0] msk;
    int op;
    sel = !p_en0_n && p_en1 && !p_en1_n;
    msk = !p_gw ? {NB{1'b1}} : (!p_bwe ? ~p_lw : '0);
    op = 0;
    if (!p_ps && !p_en0_n) begin
      if (sel) begin m_addr = p_addr; m_act = 1; op = 1; end else op = 3;
    end else if (!p_cs) begin
      if (sel) begin m_addr = p_addr; m_act = 1; op = (msk != 0) ? 2 : 1; end else op = 3;
    end else if (m_act) begin
      if (!p_go) m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
      op = (msk != 0) ? 2 : 1;
    end
    case (op)
      1: begin m_drv = 1; m_od = m_d[m_addr]; m_op = m_p[m_addr]; end
      2: begin
        for (int j = 0; j < NB; j++) if (msk[j]) begin
          m_d[m_addr][j*8 +: 8] = p_d[j*8 +: 8];
          m_p[m_addr][j] = p_p[j];
        end
        m_drv = 0;
      end
      3: begin if (!m_act) m_drv = 0; m_act = 0; end
      default: m_drv = 0;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_drv = 0; m_addr = 0;
      m_idle_pend();
    end else begin
      m_commit();
      p_addr = addr_i; p_en0_n = en0_n; p_en1 = en1; p_en1_n = en1_n;
      p_ps = pstb_n; p_cs = cstb_n; p_go = burst_go_n; p_lw = lane_wr_n;
      p_bwe = bytewr_en_n; p_gw = all_wr_n; p_d = bus_d_i; p_p = bus_p_i;
    end
  end

  // ---------------- checking ----------------
  task automatic check_bus();
    bit eoe;
    eoe = m_drv && !out_en_n;
    checks++;
    if (bus_oe !== eoe) begin
      errors++;
      $display("FAIL %s: bus_oe actual=%0b expected=%0b", cur_req, bus_oe, eoe);
    end else if (eoe && (bus_d_o !== m_od || bus_p_o !== m_op)) begin
      errors++;
      $display("FAIL %s: data actual=%h/%h expected=%h/%h", cur_req, bus_d_o, bus_p_o, m_od, m_op);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_bus();
  endtask

  task automatic idle();
    en0_n = 0; en1 = 1; en1_n = 0; pstb_n = 1; cstb_n = 1; burst_go_n = 1;
    lane_wr_n = '1; bytewr_en_n = 1; all_wr_n = 1; out_en_n = 0;
  endtask

  task automatic cread(input int a);
    idle(); cstb_n = 0; addr_i = a[AW-1:0];
    tick();
  endtask

  task automatic cwrite(input int a, input logic [DW-1:0] d, input logic [NB-1:0] p,
                        input bit gw_n, input bit bwe_n, input logic [NB-1:0] lw);
    idle(); cstb_n = 0; addr_i = a[AW-1:0]; bus_d_i = d; bus_p_i = p;
    all_wr_n = gw_n; bytewr_en_n = bwe_n; lane_wr_n = lw; out_en_n = 1;
    tick();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle();
    repeat (3) tick();
    rst = 0;
    repeat (3) tick();

    // R3: fill the array through controller-strobe global writes
    cur_req = "R3";
    for (int a = 0; a < DEPTH; a++)
      cwrite(a, {4{a[7:0] ^ 8'h5a}}, a[3:0], 0, 1, '1);
    idle(); tick();

    // R6: read latency and back-to-back reads
    cur_req = "R6";
    for (int a = 3; a < 9; a++) cread(a);
    idle(); tick(); tick();

    // R7: byte writes, unqualified lanes, global override
    cur_req = "R7";
    cwrite(5, 32'h11223344, 4'hf, 1, 0, 4'b1010);
    cread(5); idle(); tick();
    cwrite(5, 32'hdeadbeef, 4'h0, 1, 1, 4'b0000);  // not qualified: read
    idle(); tick();
    cwrite(5, 32'hcafef00d, 4'h5, 0, 1, 4'b1111);  // global write
    cread(5); idle(); tick();

    // R8: parity lanes travel with bytes
    cur_req = "R8";
    cwrite(10, 32'h01020304, 4'b1001, 0, 1, '1);
    cwrite(11, 32'ha0b0c0d0, 4'b0110, 1, 0, 4'b0011);
    cread(10); cread(11); idle(); tick();

    // R11: burst wrap and suspend
    cur_req = "R11";
    cread(22);
    idle(); burst_go_n = 0;
    repeat (5) tick();
    burst_go_n = 1;
    repeat (2) tick();
    burst_go_n = 0; all_wr_n = 0; out_en_n = 1; bus_d_i = 32'h77665544; bus_p_i = 4'ha;
    repeat (3) tick();
    cread(20); idle(); burst_go_n = 0; repeat (4) tick();

    // R2 / R10: deselect via each enable, double-cycle release
    cur_req = "R10";
    cread(7); idle(); en1 = 0; cstb_n = 0; tick();
    idle(); repeat (3) tick();
    cur_req = "R2";
    cread(8); idle(); en0_n = 1; cstb_n = 0; tick();
    idle(); repeat (2) tick();
    cread(9); idle(); en1_n = 1; pstb_n = 0; tick();
    idle(); repeat (2) tick();
    cread(9); idle(); en1 = 0; pstb_n = 0; tick();
    idle(); repeat (3) tick();

    // R4: processor strobe with en0_n high is ignored
    cur_req = "R4";
    idle(); en1 = 0; cstb_n = 0; tick();
    idle(); en0_n = 1; pstb_n = 0; addr_i = 6'd30; tick();
    idle(); repeat (2) tick();
    cread(33);
    idle(); en0_n = 1; pstb_n = 0; addr_i = 6'd40; burst_go_n = 0; tick();
    idle(); repeat (2) tick();

    // R5: processor-strobe read then late write
    cur_req = "R5";
    idle(); pstb_n = 0; addr_i = 6'd12; tick();
    idle(); all_wr_n = 0; out_en_n = 1; bus_d_i = 32'h13572468; bus_p_i = 4'h3; tick();
    cread(12); idle(); tick();
    idle(); pstb_n = 0; addr_i = 6'd13; tick();
    idle(); bytewr_en_n = 0; lane_wr_n = 4'b0110; out_en_n = 1; bus_d_i = 32'hffeeddcc; bus_p_i = 4'hf; tick();
    cread(13); idle(); tick();

    // R12: processor strobe beats controller strobe
    cur_req = "R12";
    idle(); pstb_n = 0; cstb_n = 0; all_wr_n = 0; addr_i = 6'd20; bus_d_i = 32'h0; bus_p_i = 0; tick();
    idle(); en1 = 0; cstb_n = 0; tick();
    cread(20); idle(); tick();

    // R9: asynchronous output enable and write turnaround
    cur_req = "R9";
    cread(14);
    out_en_n = 1; #1 check_bus();
    out_en_n = 0; #1 check_bus();
    idle(); tick();
    cwrite(14, 32'h89abcdef, 4'hc, 0, 1, '1);
    idle(); out_en_n = 0; tick(); tick();
    cread(14); out_en_n = 0; tick();

    // random mix across R2, R3, R5, R7, R11
    cur_req = "RND_R11";
    for (int i = 0; i < 3000; i++) begin
      en0_n = ($urandom % 6) == 0;
      en1 = ($urandom % 8) != 0;
      en1_n = ($urandom % 8) == 0;
      pstb_n = ($urandom % 4) != 0;
      cstb_n = ($urandom % 3) != 0;
      burst_go_n = $urandom % 2;
      all_wr_n = ($urandom % 5) != 0;
      bytewr_en_n = $urandom % 2;
      lane_wr_n = $urandom;
      out_en_n = ($urandom % 4) == 0;
      addr_i = $urandom;
      bus_d_i = $urandom;
      bus_p_i = $urandom;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (%s): actual=timeout expected=completion", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule